// File: doc/BRIEF.md
# Unary Decimal Digit Adder with Carry Cells

This block adds two decimal operands one digit position at a time. Each digit arrives as a count of unit spikes rather than as a binary code. One operand is the A value and the other is the B value, either plain or already complemented upstream. Spike counts can come in over one or several cycles. A start pulse then closes the operation.

Two structures see every accepted spike. A modulo accumulator drops each full group of ten, so every digit it holds stays in the range 0..9. It hands the reduced digits over when the start pulse is accepted. Beside it sits one carry cell per digit. All cells are judged on the same start edge. A cell whose total is above nine gives up ten spikes and raises a carry worth one unit of the next higher position. The top cell has no higher neighbour, so its overflow becomes a second completion flag that comes late. The downstream sign stage counts the flags: two flags means a non-negative result, one flag means a negative subtraction result. The sign decision itself is made outside this block.

A fixed run of cycles follows every start. During that run the block ignores new work. In the same cycle that raises the first flag it also wipes whatever count is left in the carry cells, so nothing carries over into the next operation.

Top module: `udig_adder`

## Requirements
- R1: After reset, `sum_o` and `carry_o` are zero and `busy_o`, `done_o` and `ovf_o` are low.
- R2: The cycle after an accepted start, field i of `sum_o` (bits [4i+3:4i], digit 0 lowest) holds the total of A and B spikes given for digit i in that operation, modulo 10. The value holds until the next accepted start. Each operation must keep every digit total at 19 or below. Digit i's counts sit at bits [CW*i+CW-1:CW*i] of each count input.
- R3: For each digit i below the top one, `carry_o[i]` is 1 exactly when digit i's total exceeds 9. It is one unit of digit i+1. It is updated at the same time as `sum_o` and held with it.
- R4: `done_o` pulses for one cycle, and is first seen 10 falling edges after the falling edge where start was driven (9 clock edges after the accepting edge).
- R5: `ovf_o` pulses for one cycle, NDIG*9 clock edges after the accepting edge, only when the top digit's total exceeds 9. Otherwise no second flag appears.
- R6: Spikes given in the same cycle as an accepted start belong to that operation.
- R7: From the accepting edge until the edge after the `ovf_o` slot, `busy_o` is high. During that window start pulses and spikes are ignored, and `sum_o` and `carry_o` do not change.
- R8: Counts left in the carry cells by one operation have no effect on the carries of any later operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| spk_vld_i | input | 1 | Spike counts on the count inputs are valid this cycle |
| a_cnt_i | input | NDIG*CW | Per-digit spike counts of operand A |
| b_cnt_i | input | NDIG*CW | Per-digit spike counts of operand B (plain or complemented) |
| start_i | input | 1 | Closes the operation and triggers forwarding and carry evaluation |
| busy_o | output | 1 | An operation's flag window is running |
| sum_o | output | NDIG*4 | Modulo-10 digits, digit 0 in the low nibble |
| carry_o | output | NDIG-1 | Carry spike into digit i+1 from digit i |
| done_o | output | 1 | First completion flag |
| ovf_o | output | 1 | Second completion flag, raised by top-digit overflow |

## Verification
Two events can fall in the same cycle. Spikes can arrive together with the start pulse that closes the operation, and the carry-cell wipe coincides with the first flag. The bench alternates between loading everything before start and putting the last spikes on the start cycle. Results that leave out those last spikes show up as wrong digits and carries. Every operation also injects spikes and a start deep inside its busy window. Across a full sweep of low-digit and top-digit totals, any stale cell count or wrongly accepted input shows up as a carry or a digit that breaks the next operation's arithmetic.

// File: rtl/udig_pkg.sv
package udig_pkg;
    localparam int unsigned DIG_W = 4;
    localparam int unsigned RADIX = 10;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;
endpackage

// File: rtl/udig_acc.sv
module udig_acc #(
    parameter int unsigned NDIG = 3,
    parameter int unsigned CW   = 5
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           add_i,
    input  logic                           take_i,
    input  logic [NDIG*CW-1:0]             a_i,
    input  logic [NDIG*CW-1:0]             b_i,
    output logic [NDIG*udig_pkg::DIG_W-1:0] sum_o
);
    import udig_pkg::*;

    // worst single-cycle total: held digit plus two full-scale counts
    localparam int unsigned MAXV = (RADIX - 1) + 2 * ((1 << CW) - 1);
    localparam int unsigned TW   = $clog2(MAXV + 1);
    localparam int unsigned NGRP = MAXV / RADIX;

    typedef struct packed {
        logic [NDIG-1:0][DIG_W-1:0] acc;
        logic [NDIG-1:0][DIG_W-1:0] sum;
    } acc_st_t;

    acc_st_t st_d, st_q;

    always_comb begin
        logic [TW-1:0] t;
        st_d = st_q;
        for (int i = 0; i < NDIG; i++) begin
            t = TW'(st_q.acc[i]);
            if (add_i) begin
                t = t + TW'(a_i[i*CW +: CW]) + TW'(b_i[i*CW +: CW]);
            end
            // drop whole groups of ten, one compare-subtract per possible group
            for (int g = 0; g < NGRP; g++) begin
                if (t >= TW'(RADIX)) begin
                    t = t - TW'(RADIX);
                end
            end
            if (take_i) begin
                st_d.sum[i] = t[DIG_W-1:0];
                st_d.acc[i] = '0;
            end else begin
                st_d.acc[i] = t[DIG_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sum_o = st_q.sum;

    for (genvar gi = 0; gi < NDIG; gi++) begin : g_chk
        p_digit_below_radix_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.acc[gi] < DIG_W'(RADIX)) && (st_q.sum[gi] < DIG_W'(RADIX)))
            else $error("accumulator digit %0d out of range", gi);
    end
endmodule

// File: rtl/udig_cell.sv
module udig_cell #(
    parameter int unsigned CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          add_i,
    input  logic [CW-1:0] a_i,
    input  logic [CW-1:0] b_i,
    input  logic          eval_i,
    input  logic          clr_i,
    output logic          over_o
);
    import udig_pkg::*;

    localparam int unsigned TW = CW + 2;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          over;
    } cell_st_t;

    cell_st_t st_d, st_q;

    always_comb begin
        logic [TW-1:0] tot;
        st_d = st_q;
        tot  = TW'(st_q.cnt);
        if (add_i) begin
            tot = tot + TW'(a_i) + TW'(b_i);
        end
        if (eval_i) begin
            if (tot > TW'(RADIX - 1)) begin
                st_d.over = 1'b1;
                st_d.cnt  = CW'(tot - TW'(RADIX));
            end else begin
                st_d.over = 1'b0;
                st_d.cnt  = CW'(tot);
            end
        end else if (clr_i) begin
            if (st_q.cnt < CW'(RADIX)) begin
                st_d.cnt = '0;
            end
        end else begin
            st_d.cnt = CW'(tot);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign over_o = st_q.over;

    p_clear_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (st_q.cnt == '0))
        else $error("cell kept a leftover count after clear");

    p_eval_leaves_digit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        eval_i |=> (st_q.cnt < CW'(RADIX)))
        else $error("cell count not reduced below ten by evaluation");

    p_flag_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !eval_i |=> $stable(st_q.over))
        else $error("carry flag moved without evaluation");
endmodule

// File: rtl/udig_seq.sv
module udig_seq #(
    parameter int unsigned NDIG = 3,
    parameter int unsigned DLY  = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic top_over_i,
    output logic busy_o,
    output logic done_o,
    output logic ovf_o,
    output logic clr_o
);
    import udig_pkg::*;

    localparam int unsigned LAST = DLY * NDIG;
    localparam int unsigned TMW  = $clog2(LAST + 1);

    typedef struct packed {
        seq_state_e     st;
        logic [TMW-1:0] tmr;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.st)
            SEQ_IDLE: begin
                if (start_i) begin
                    st_d.st  = SEQ_RUN;
                    st_d.tmr = '0;
                end
            end
            SEQ_RUN: begin
                if (st_q.tmr == TMW'(LAST)) begin
                    st_d.st = SEQ_IDLE;
                end else begin
                    st_d.tmr = st_q.tmr + 1'b1;
                end
            end
            default: st_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{st: SEQ_IDLE, tmr: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = (st_q.st == SEQ_RUN);
    assign done_o = busy_o && (st_q.tmr == TMW'(DLY));
    assign clr_o  = busy_o && (st_q.tmr == TMW'(DLY));
    assign ovf_o  = busy_o && (st_q.tmr == TMW'(LAST)) && top_over_i;

    p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o)
        else $error("first flag longer than one cycle");

    p_ovf_apart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> !done_o)
        else $error("both flags in one cycle");

    p_ovf_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> !ovf_o && !busy_o)
        else $error("second flag not the last cycle of the window");
endmodule

// File: rtl/udig_adder.sv
module udig_adder #(
    parameter int unsigned NDIG = 3,
    parameter int unsigned CW   = 5,
    parameter int unsigned DLY  = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 spk_vld_i,
    input  logic [NDIG*CW-1:0]   a_cnt_i,
    input  logic [NDIG*CW-1:0]   b_cnt_i,
    input  logic                 start_i,
    output logic                 busy_o,
    output logic [NDIG*4-1:0]    sum_o,
    output logic [NDIG-2:0]      carry_o,
    output logic                 done_o,
    output logic                 ovf_o
);
    logic            busy;
    logic            take;
    logic            add;
    logic            clr;
    logic [NDIG-1:0] over;

    assign take = start_i & ~busy;
    assign add  = spk_vld_i & ~busy;

    udig_acc #(.NDIG(NDIG), .CW(CW)) i_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .add_i  (add),
        .take_i (take),
        .a_i    (a_cnt_i),
        .b_i    (b_cnt_i),
        .sum_o  (sum_o)
    );

    for (genvar g = 0; g < NDIG; g++) begin : g_cell
        udig_cell #(.CW(CW)) i_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .add_i  (add),
            .a_i    (a_cnt_i[g*CW +: CW]),
            .b_i    (b_cnt_i[g*CW +: CW]),
            .eval_i (take),
            .clr_i  (clr),
            .over_o (over[g])
        );
    end

    assign carry_o = over[NDIG-2:0];

    udig_seq #(.NDIG(NDIG), .DLY(DLY)) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .top_over_i (over[NDIG-1]),
        .busy_o     (busy),
        .done_o     (done_o),
        .ovf_o      (ovf_o),
        .clr_o      (clr)
    );

    assign busy_o = busy;

    p_sum_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(sum_o) && $stable(carry_o))
        else $error("result moved inside the busy window");
endmodule

// File: tb/test_udig_adder.sv
module test_udig_adder;
    localparam int ND  = 3;
    localparam int CW  = 5;
    localparam int DLY = 9;
    localparam int LST = DLY * ND;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              spk_vld;
    logic [ND*CW-1:0]  a_cnt;
    logic [ND*CW-1:0]  b_cnt;
    logic              start;
    logic              busy;
    logic [ND*4-1:0]   sum;
    logic [ND-2:0]     carry;
    logic              done;
    logic              ovf;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    udig_adder #(.NDIG(ND), .CW(CW), .DLY(DLY)) i_udig_adder (
        .clk(clk), .rst_n(rst_n), .spk_vld_i(spk_vld), .a_cnt_i(a_cnt),
        .b_cnt_i(b_cnt), .start_i(start), .busy_o(busy), .sum_o(sum),
        .carry_o(carry), .done_o(done), .ovf_o(ovf)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_op(input int t0, input int t1, input int t2, input bit mode);
        int t[ND];
        logic [ND*CW-1:0] av, bv;
        logic [ND*4-1:0]  exp_sum;
        logic [ND-2:0]    exp_car;
        int bad_done, bad_ovf, bad_busy;
        t = '{t0, t1, t2};
        av = '0; bv = '0; exp_sum = '0; exp_car = '0;
        for (int i = 0; i < ND; i++) begin
            av[i*CW +: CW] = CW'(t[i] / 2);
            bv[i*CW +: CW] = CW'(t[i] - t[i] / 2);
            exp_sum[i*4 +: 4] = 4'(t[i] % 10);
            if (i < ND - 1) exp_car[i] = (t[i] > 9);
        end
        if (!mode) begin
            spk_vld = 1'b1; a_cnt = av; b_cnt = bv;
            @(negedge clk);
            spk_vld = 1'b0; a_cnt = '0; b_cnt = '0; start = 1'b1;
        end else begin
            // R6: second half arrives with the start pulse
            spk_vld = 1'b1; a_cnt = av; b_cnt = '0;
            @(negedge clk);
            a_cnt = '0; b_cnt = bv; start = 1'b1;
        end
        @(negedge clk);
        spk_vld = 1'b0; start = 1'b0; a_cnt = '0; b_cnt = '0;
        chk(sum == exp_sum, mode ? "R2 R6 sum digits" : "R2 sum digits", int'(sum), int'(exp_sum));
        chk(carry == exp_car, mode ? "R3 R6 R8 carries" : "R3 R8 carries", int'(carry), int'(exp_car));
        bad_done = 0; bad_ovf = 0; bad_busy = 0;
        for (int j = 1; j <= LST + 1; j++) begin
            if (done !== (j == DLY + 1)) bad_done++;
            if (ovf !== ((j == LST + 1) && (t2 > 9))) bad_ovf++;
            if (busy !== 1'b1) bad_busy++;
            if (j == 5) begin
                spk_vld = 1'b1; start = 1'b1;
                for (int i = 0; i < ND; i++) begin
                    a_cnt[i*CW +: CW] = CW'(3);
                    b_cnt[i*CW +: CW] = CW'(3);
                end
            end else if (j == 6) begin
                spk_vld = 1'b0; start = 1'b0; a_cnt = '0; b_cnt = '0;
            end
            @(negedge clk);
        end
        chk(bad_done == 0, "R4 first flag timing", bad_done, 0);
        chk(bad_ovf == 0, "R5 second flag timing", bad_ovf, 0);
        chk(bad_busy == 0 && busy == 1'b0, "R7 busy window", bad_busy + int'(busy), 0);
        chk(sum == exp_sum && carry == exp_car, "R7 result unchanged by busy input",
            int'(sum), int'(exp_sum));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; spk_vld = 1'b0; start = 1'b0; a_cnt = '0; b_cnt = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sum == '0 && carry == '0, "R1 reset result", int'(sum), 0);
        chk(!busy && !done && !ovf, "R1 reset flags", int'({busy, done, ovf}), 0);
        // R8: leftover fives must not pair up into a carry
        run_op(5, 5, 5, 1'b0);
        run_op(5, 5, 5, 1'b1);
        run_op(19, 10, 19, 1'b1);
        for (int t0 = 0; t0 < 20; t0++) begin
            for (int t2 = 0; t2 < 20; t2++) begin
                run_op(t0, (t0 * 7 + t2 * 3) % 20, t2, 1'((t0 + t2) % 2));
            end
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule